// File: doc/BRIEF.md
# Cross-Clock Shadow Word Memory with Toggle-Event Writes

This block keeps a 1024-word, 32-bit copy of state that is produced in one clock domain (the source) and consumed in another (the destination). The source side presents a word index, a data word and a single toggle line. Every change in the toggle's level, rising or falling, stands for exactly one write. Only the toggle is carried across the boundary, through a short chain of synchronizing flops. In the destination domain an edge detector turns each observed level change into a one-cycle write pulse. That pulse stores the source's held data at the held index. Index and data are never synchronized. They are sampled when the pulse fires, so the source must hold them steady and space its toggles several destination cycles apart.

The destination reads any word combinationally by index. A saturating diagnostic counter counts write pulses that follow the previous pulse too closely, which shows where a source breaks the spacing contract. Each domain has its own active-low asynchronous reset. The destination reset clears the memory, the synchronizer, the edge history and both counters. The edge history is primed from the synchronized toggle, so releasing the destination reset while the toggle sits high does not produce a write.

Top module: `xclk_shadow_ram`

## Requirements
- R1: While and after the destination reset, every index reads 0 and the close-write counter reads 0.
- R2: A toggle change launched by the source register becomes a destination write pulse after the two synchronizer flops. The memory update is registered on the following destination edge. For a toggle driven just before a source edge, the word is readable exactly three destination cycles after the destination cycle in which it was driven.
- R3: A toggle held at a constant level never writes, even when the index and data inputs change.
- R4: The read data always equals the word stored at the presented read index, with no clock delay.
- R5: Repeated writes to one index leave the last written value, and a write never changes any other index.
- R6: A write pulse increments the close-write counter when fewer than MIN_GAP (default 3) destination cycles have passed since the previous pulse. The first pulse after a destination reset is never counted. Counted writes still store their data if index and data were held.
- R7: The close-write counter stops at its all-ones value (0xFFFF at the default width) and never wraps or decreases.
- R8: Releasing the destination reset while the synchronized toggle is high creates no write and no count. The next toggle change then writes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_toggle | input | 1 | Write event line; each level change requests one write |
| src_index | input | 10 | Word index of the requested write |
| src_data | input | 32 | Data word of the requested write |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_rd_index | input | 10 | Word index to read |
| dst_rd_data | output | 32 | Stored word at dst_rd_index, combinational |
| dst_close_count | output | 16 | Saturating count of writes that arrived too close to the previous one |

## Verification
Single writes to the lowest, middle and highest index separate a correct index decode from stuck or truncated index bits. A triple write to one slot followed by eight scattered writes separates last-write-wins from merged or misdirected updates. Index and data are changed with the toggle held, which shows that writes follow toggle edges and not levels. Write pairs spaced one, two and three destination cycles apart pin the close-write threshold on both sides. A forty-write burst against a narrowed counter reaches saturation. A destination-only reset with the toggle left high shows that reset release adds no write.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

  // A pulse is "close" when fewer than min_gap destination cycles separate
  // it from the previous one; gap counts cycles since that pulse, from zero.
  function automatic logic gap_too_close(input int unsigned gap,
                                         input int unsigned min_gap);
    return (gap + 1) < min_gap;
  endfunction

  // Saturating increment limit check.
  function automatic logic can_count(input int unsigned value,
                                     input int unsigned max_value);
    return value < max_value;
  endfunction

endpackage

// File: rtl/xsr_toggle_sync.sv
module xsr_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);

  localparam int WARM_LIM = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_LIM + 1);

  logic [SYNC_STAGES-1:0] chain;
  logic                   hist;
  logic [WARM_W-1:0]      warm;
  logic                   synced;
  logic                   armed;

  assign synced = chain[SYNC_STAGES-1];
  assign armed  = (warm == WARM_W'(WARM_LIM));
  assign pulse  = armed & (synced ^ hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      hist  <= 1'b0;
      warm  <= '0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], tgl_in};
      hist  <= synced;
      if (!armed) warm <= warm + 1'b1;
    end
  end

  // R8: until the chain and history are primed, no pulse may leave.
  p_quiet_warmup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(warm) == '0 |-> !pulse);

endmodule

// File: rtl/xsr_gap_monitor.sv
module xsr_gap_monitor #(
  parameter int MIN_GAP = 3,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  output logic [CNT_W-1:0] close_cnt
);
  import xsr_pkg::*;

  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [GAP_W-1:0] gap;
  logic             seen;
  logic             close_evt;

  assign close_evt = pulse & seen & gap_too_close(32'(gap), MIN_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      seen      <= 1'b0;
      close_cnt <= '0;
    end else begin
      if (pulse) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != GAP_TOP) begin
        gap <= gap + 1'b1;
      end
      if (close_evt && can_count(32'(close_cnt), 32'(CNT_TOP)))
        close_cnt <= close_cnt + 1'b1;
    end
  end

  // R7: the counter never goes down.
  p_count_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> close_cnt >= $past(close_cnt));

  // R7: once at the top it stays there.
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    close_cnt == CNT_TOP |=> close_cnt == CNT_TOP);

  // R6: without a close event the counter holds.
  p_count_only_on_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> $stable(close_cnt));

  // R6: a pulse right after another pulse is always counted unless saturated.
  p_back_to_back_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $past(pulse) && $past(seen) && close_cnt != CNT_TOP) |=>
      close_cnt == $past(close_cnt) + 1'b1);

endmodule

// File: rtl/xsr_shadow_mem.sv
module xsr_shadow_mem #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  // R2: a write to the watched index is visible on the next cycle.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=>
      (rd_data == $past(wr_data)) || (rd_idx != $past(rd_idx)));

  // R3/R4: with no write the watched word is steady.
  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data == $past(rd_data)) || (rd_idx != $past(rd_idx)));

endmodule

// File: rtl/xclk_shadow_ram.sv
module xclk_shadow_ram #(
  parameter int DEPTH       = 1024,
  parameter int DATA_W      = 32,
  parameter int MIN_GAP     = 3,
  parameter int CLOSE_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DEPTH)
) (
  input  logic               src_clk,
  input  logic               src_rst_n,
  input  logic               src_toggle,
  input  logic [IDX_W-1:0]   src_index,
  input  logic [DATA_W-1:0]  src_data,
  input  logic               dst_clk,
  input  logic               dst_rst_n,
  input  logic [IDX_W-1:0]   dst_rd_index,
  output logic [DATA_W-1:0]  dst_rd_data,
  output logic [CLOSE_W-1:0] dst_close_count
);

  // Source launch registers: the only flops the destination samples.
  logic              l_tgl;
  logic [IDX_W-1:0]  l_idx;
  logic [DATA_W-1:0] l_data;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      l_tgl  <= 1'b0;
      l_idx  <= '0;
      l_data <= '0;
    end else begin
      l_tgl  <= src_toggle;
      l_idx  <= src_index;
      l_data <= src_data;
    end
  end

  logic wr_pulse;

  xsr_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (dst_clk),
    .rst_n  (dst_rst_n),
    .tgl_in (l_tgl),
    .pulse  (wr_pulse)
  );

  xsr_gap_monitor #(.MIN_GAP(MIN_GAP), .CNT_W(CLOSE_W)) u_gap (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .pulse     (wr_pulse),
    .close_cnt (dst_close_count)
  );

  xsr_shadow_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .wr_en   (wr_pulse),
    .wr_idx  (l_idx),
    .wr_data (l_data),
    .rd_idx  (dst_rd_index),
    .rd_data (dst_rd_data)
  );

endmodule

// File: tb/xclk_shadow_ram_bench.sv
module xclk_shadow_ram_bench;

  localparam int SRC_PERIOD = 10;
  localparam int DST_PERIOD = 30;
  localparam int MIN_GAP    = 3;
  localparam int CW         = 5;
  localparam int CMAX       = (1 << CW) - 1;
  localparam int LATENCY    = 3;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  always #(SRC_PERIOD / 2) src_clk = ~src_clk;
  initial begin
    #2;
    forever #(DST_PERIOD / 2) dst_clk = ~dst_clk;
  end

  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic          src_toggle = 1'b0;
  logic [9:0]    src_index = '0;
  logic [31:0]   src_data = '0;
  logic [9:0]    dst_rd_index = '0;
  logic [31:0]   dst_rd_data;
  logic [CW-1:0] dst_close_count;

  xclk_shadow_ram #(.CLOSE_W(CW), .MIN_GAP(MIN_GAP)) u_xclk_shadow_ram (
    .src_clk         (src_clk),
    .src_rst_n       (src_rst_n),
    .src_toggle      (src_toggle),
    .src_index       (src_index),
    .src_data        (src_data),
    .dst_clk         (dst_clk),
    .dst_rst_n       (dst_rst_n),
    .dst_rd_index    (dst_rd_index),
    .dst_rd_data     (dst_rd_data),
    .dst_close_count (dst_close_count)
  );

  typedef struct {
    int          due;
    int          idx;
    logic [31:0] data;
    bit          close;
  } ev_t;

  ev_t         evq[$];
  logic [31:0] exp_mem[int];
  int          exp_cnt = 0;
  int          cyc = 0;
  int          last_drive = 0;
  bit          have_prev = 0;
  int          checks = 0;
  int          failures = 0;
  string       cur_req = "R1";

  function automatic logic [31:0] model_word(input int idx);
    if (exp_mem.exists(idx)) return exp_mem[idx];
    return 32'd0;
  endfunction

  task automatic model_reset();
    exp_mem.delete();
    evq.delete();
    exp_cnt   = 0;
    have_prev = 0;
  endtask

  // One destination cycle: retire due writes, then compare both outputs.
  task automatic step();
    logic [31:0] ew;
    @(negedge dst_clk);
    cyc++;
    while (evq.size() > 0 && evq[0].due <= cyc) begin
      exp_mem[evq[0].idx] = evq[0].data;
      if (evq[0].close && exp_cnt < CMAX) exp_cnt++;
      void'(evq.pop_front());
    end
    ew = model_word(int'(dst_rd_index));
    checks++;
    if (dst_rd_data !== ew) begin
      failures++;
      $display("FAIL %s word[%0h] cyc %0d: actual %h expected %h",
               cur_req, dst_rd_index, cyc, dst_rd_data, ew);
    end
    checks++;
    if (dst_close_count !== CW'(exp_cnt)) begin
      failures++;
      $display("FAIL %s close count cyc %0d: actual %0d expected %0d",
               cur_req, cyc, dst_close_count, exp_cnt);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic put(input int idx, input logic [31:0] d);
    bit c;
    c = have_prev && ((cyc - last_drive) < MIN_GAP);
    have_prev  = 1;
    last_drive = cyc;
    src_index    = idx[9:0];
    src_data     = d;
    src_toggle   = ~src_toggle;
    dst_rd_index = idx[9:0];
    evq.push_back('{due: cyc + LATENCY, idx: idx, data: d, close: c});
  endtask

  task automatic peek(input int idx);
    dst_rd_index = idx[9:0];
    step();
  endtask

  initial begin
    // R1: reset state while held and after release.
    cur_req = "R1";
    idle(3);
    src_rst_n = 1'b1;
    idle(1);
    dst_rst_n = 1'b1;
    idle(4);
    peek(0); peek(1); peek('h200); peek('h3FF);

    // R2: single writes at low, middle, top indices; exact latency.
    cur_req = "R2";
    put('h000, 32'hDEAD_BEEF); idle(6);
    put('h200, 32'h1234_5678); idle(6);
    put('h3FF, 32'hCAFE_F00D); idle(6);

    // R4: combinational read across indices.
    cur_req = "R4";
    peek('h000); peek('h200); peek('h3FF); peek('h001); peek('h1FF);

    // R5: last write wins, neighbours untouched.
    cur_req = "R5";
    put('h100, 32'h1111_1111); idle(4);
    put('h100, 32'h2222_2222); idle(4);
    put('h100, 32'h3333_3333); idle(6);
    for (int k = 0; k < 8; k++) begin
      put(('h013 * (k + 1) * 7) % 1024, 32'hA5A5_0000 + k); idle(4);
    end
    for (int k = 0; k < 8; k++) peek(('h013 * (k + 1) * 7) % 1024);
    peek('h100); peek('h007); peek('h0FF); peek('h2FF); peek('h000);

    // R3: index and data move, toggle stays; no write may appear.
    cur_req = "R3";
    src_index    = 10'h000;
    src_data     = 32'hBEEF_CAFE;
    dst_rd_index = 10'h000;
    idle(10);
    src_index    = 10'h3FF;
    src_data     = 32'h0000_0001;
    idle(4);
    peek('h3FF);

    // R6: spacing 2 counts, spacing 3 does not, spacing 1 counts.
    cur_req = "R6";
    put('h050, 32'h0BAD_CAFE); idle(2);
    put('h050, 32'h0BAD_CAFE); idle(3);
    put('h050, 32'h0BAD_CAFE); idle(1);
    put('h050, 32'h0BAD_CAFE); idle(6);

    // R7: a back-to-back burst drives the counter to saturation.
    cur_req = "R7";
    for (int k = 0; k < 40; k++) begin
      put('h060, 32'h7777_0060); idle(1);
    end
    idle(6);
    put('h060, 32'h7777_0060); idle(1);
    put('h060, 32'h7777_0060); idle(6);

    // R8: destination reset with the toggle left high.
    cur_req = "R8";
    if (src_toggle == 1'b0) begin
      put('h070, 32'h0000_0070); idle(6);
    end
    dst_rst_n = 1'b0;
    model_reset();
    idle(3);
    dst_rst_n = 1'b1;
    dst_rd_index = 10'h070;
    idle(8);
    peek('h060);
    put('h071, 32'h8888_0071); idle(6);
    put('h072, 32'h8888_0072); idle(1);
    put('h072, 32'h8888_0072); idle(6);
    peek('h071);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge dst_clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule